// File: doc/BRIEF.md
# Outbound Retry Limit Abort Counter

This block sits beside the outbound master of a bus bridge and keeps watch over one pending outbound request at a time. Each time the addressed target answers that request with a retry, a counter advances. When the count reaches a programmed ceiling, the block raises a one-cycle abort so that the master can give up on the failing request instead of retrying forever.

The ceiling comes from a 3-bit code held in a control register. Code zero disables the ceiling altogether. Every other code selects a power of two between 8 and 512. The code is captured at the moment a request starts, so software may rewrite the register at any time without disturbing a request already in flight. Request start, target retry and request completion arrive as single-cycle strobes from the protocol engine. The current count is visible on an output port.

Top module: `retry_abort_ctr`

## Requirements
- R1: With a captured limit code of 0, no abort is ever raised, however many retries arrive.
- R2: A captured code c in 1..7 sets the limit to 2^(c+2) retries (8, 16, 32, 64, 128, 256, 512). The abort follows the retry that brings the count to that value and no earlier one.
- R3: abort_o is high for exactly one cycle. That cycle is the one after the clock edge that samples the limit-reaching retry, and in that cycle retry_cnt_o equals the limit.
- R4: After an abort, further retries leave retry_cnt_o unchanged and raise no second abort until a new request starts.
- R5: A req_start_i strobe clears retry_cnt_o to 0 on the next cycle and captures limit_code_i for the new request. It wins over a retry or completion strobe in the same cycle.
- R6: A req_done_i strobe without req_start_i clears retry_cnt_o to 0 on the next cycle and ends the request.
- R7: A change of limit_code_i while a request is pending has no effect on that request's limit.
- R8: Retry strobes while no request is pending are ignored: retry_cnt_o stays unchanged and no abort is raised.
- R9: In no-limit mode the count saturates at 1023, the all-ones value of the 10-bit counter, and never wraps.
- R10: After reset, retry_cnt_o is 0, abort_o is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| limit_code_i | input | 3 | Retry limit code from the control register (0 = no limit) |
| req_start_i | input | 1 | Strobe: a new outbound request begins |
| tgt_retry_i | input | 1 | Strobe: the target answered the pending request with a retry |
| req_done_i | input | 1 | Strobe: the pending request completed |
| abort_o | output | 1 | One-cycle pulse: abort the pending request |
| retry_cnt_o | output | 10 | Retries counted for the current request |

## Verification
Every nonzero limit code is swept. For each one, the bench stops one retry short of the limit to show that no abort comes early, then adds the last retry to show that the abort lands exactly there. Retries issued after the abort show that the count is frozen. Code 0 is driven past 512 and past 1023 retries, which separates "no limit" from "largest limit" and saturation from wrap-around. Further sequences cover the remaining cases:
- rewriting the code mid-request;
- retries while idle;
- a completion in the middle of counting;
- a start arriving together with a retry.

These separate correct limit capture, idle masking and strobe priority from their plausible faults.

// File: rtl/retry_abort_pkg.sv
package retry_abort_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_HALTED = 2'd2
   } req_state_e;

   // counter width needed so the largest limit fits
   function automatic int cnt_width(input int code_w, input int base_log2);
      return (2 ** code_w) + base_log2 - 1;
   endfunction

endpackage

// File: rtl/retry_limit_decode.sv
module retry_limit_decode #(
   parameter int CODE_W    = 3,
   parameter int BASE_LOG2 = 3,
   parameter int CNT_W     = 10
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]  limit_o
);
   localparam int NCODE = 2 ** CODE_W;

   logic [CNT_W-1:0] tbl [NCODE];

   generate
      if (CNT_W < (NCODE + BASE_LOG2 - 1)) begin : g_bad_width
         $error("retry_limit_decode: CNT_W too narrow for the largest limit");
      end
      for (genvar g = 0; g < NCODE; g++) begin : g_entry
         if (g == 0) begin : g_none
            assign tbl[g] = '0;
         end else begin : g_pow
            assign tbl[g] = CNT_W'(1) << (g + BASE_LOG2 - 1);
         end
      end
   endgenerate

   assign limit_o = tbl[code_i];

endmodule

// File: rtl/retry_count_core.sv
module retry_count_core #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             done_i,
   input  logic             count_en_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + CNT_W'(1);
   assign hit_o   = (limit_q != '0) && (cnt_inc == limit_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         limit_q <= '0;
      end else if (start_i) begin
         cnt_q   <= '0;
         limit_q <= limit_i;
      end else if (done_i) begin
         cnt_q <= '0;
      end else if (count_en_i && (cnt_q != '1)) begin
         cnt_q <= cnt_inc;
      end
   end

   assign cnt_o = cnt_q;

   // R9
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '1) && !start_i && !done_i |=> cnt_q == '1);
   // R5
   start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> cnt_q == '0);

endmodule

// File: rtl/retry_abort_fsm.sv
module retry_abort_fsm
   import retry_abort_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       done_i,
   input  logic       retry_i,
   input  logic       hit_i,
   output logic       count_en_o,
   output logic       abort_o,
   output req_state_e state_o
);
   req_state_e state_q, state_d;
   logic       abort_q;
   logic       fire;

   assign count_en_o = (state_q == ST_ACTIVE) && retry_i && !start_i && !done_i;
   assign fire       = count_en_o && hit_i;

   always_comb begin
      state_d = state_q;
      if (start_i)    state_d = ST_ACTIVE;
      else if (done_i) state_d = ST_IDLE;
      else if (fire)  state_d = ST_HALTED;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         abort_q <= fire;
      end
   end

   assign abort_o = abort_q;
   assign state_o = state_q;

   // R3
   abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |=> !abort_o);
   // R4
   halted_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HALTED) |=> !abort_o);

endmodule

// File: rtl/retry_abort_ctr.sv
module retry_abort_ctr
   import retry_abort_pkg::*;
#(
   parameter int CODE_W    = 3,
   parameter int BASE_LOG2 = 3,
   localparam int CNT_W    = cnt_width(CODE_W, BASE_LOG2)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CODE_W-1:0] limit_code_i,
   input  logic             req_start_i,
   input  logic             tgt_retry_i,
   input  logic             req_done_i,
   output logic             abort_o,
   output logic [CNT_W-1:0] retry_cnt_o
);
   generate
      if (CODE_W < 1 || BASE_LOG2 < 1) begin : g_bad_param
         $error("retry_abort_ctr: CODE_W and BASE_LOG2 must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] limit_dec;
   logic             hit;
   logic             count_en;
   req_state_e       state;

   retry_limit_decode #(
      .CODE_W   (CODE_W),
      .BASE_LOG2(BASE_LOG2),
      .CNT_W    (CNT_W)
   ) u_decode (
      .code_i (limit_code_i),
      .limit_o(limit_dec)
   );

   retry_count_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (req_start_i),
      .done_i    (req_done_i),
      .count_en_i(count_en),
      .limit_i   (limit_dec),
      .hit_o     (hit),
      .cnt_o     (retry_cnt_o)
   );

   retry_abort_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (req_start_i),
      .done_i    (req_done_i),
      .retry_i   (tgt_retry_i),
      .hit_i     (hit),
      .count_en_o(count_en),
      .abort_o   (abort_o),
      .state_o   (state)
   );

   // R6
   done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_done_i && !req_start_i |=> retry_cnt_o == '0);
   // R8
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != ST_ACTIVE) && !req_start_i && !req_done_i |=> $stable(retry_cnt_o));
   // R2
   abort_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> (retry_cnt_o != '0) && ($countones(retry_cnt_o) == 1));
   // R1
   abort_from_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> $past(state) == ST_ACTIVE);

endmodule

// File: tb/retry_abort_ctr_tb_top.sv
module retry_abort_ctr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] code = 3'd0;
   logic       start = 1'b0, retry = 1'b0, done = 1'b0;
   logic       abort;
   logic [9:0] cnt;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   int abort_seen = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   retry_abort_ctr dut_i (
      .clk_i(clk), .rst_ni(rst_n), .limit_code_i(code),
      .req_start_i(start), .tgt_retry_i(retry), .req_done_i(done),
      .abort_o(abort), .retry_cnt_o(cnt)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (abort) abort_seen <= abort_seen + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock with the given strobes, then sample 1 ns after the edge
   task automatic step(input bit s, input bit r, input bit d);
      start = s; retry = r; done = d;
      @(posedge clk); #1;
      start = 1'b0; retry = 1'b0; done = 1'b0;
   endtask

   function automatic int lim_of(input int c);
      return 1 << (c + 2);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R10
      chk("R10 cnt", cnt, 0);
      chk("R10 abort", abort, 0);

      // R8: retries while idle
      for (int i = 0; i < 5; i++) step(0, 1, 0);
      chk("R8 idle cnt", cnt, 0);
      chk("R8 idle abort", abort_seen, 0);

      // R2/R3/R4 sweep of every nonzero code
      for (int c = 1; c < 8; c++) begin
         code = 3'(c);
         step(1, 0, 0);
         chk("R5 start cnt", cnt, 0);
         for (int i = 0; i < lim_of(c) - 1; i++) step(0, 1, 0);
         chk("R2 before limit cnt", cnt, lim_of(c) - 1);
         chk("R2 no early abort", abort, 0);
         step(0, 1, 0);
         chk("R3 abort at limit", abort, 1);
         chk("R3 cnt at limit", cnt, lim_of(c));
         step(0, 0, 0);
         chk("R3 single pulse", abort, 0);
         abort_seen = 0;
         step(0, 1, 0);
         step(0, 1, 0);
         chk("R4 frozen cnt", cnt, lim_of(c));
         chk("R4 no second abort", abort_seen, 0);
         step(0, 0, 1);
         chk("R6 done after abort", cnt, 0);
      end

      // R1 and R9: no-limit mode
      code = 3'd0;
      step(1, 0, 0);
      abort_seen = 0;
      for (int i = 0; i < 600; i++) step(0, 1, 0);
      chk("R1 cnt 600", cnt, 600);
      for (int i = 0; i < 500; i++) step(0, 1, 0);
      chk("R9 saturate", cnt, 1023);
      chk("R1 no abort", abort_seen, 0);

      // R7: code change mid-request
      code = 3'd1;
      step(1, 0, 0);
      code = 3'd7;
      for (int i = 0; i < 8; i++) step(0, 1, 0);
      chk("R7 old limit kept", abort, 1);
      step(0, 0, 1);

      // R6: completion mid-count
      code = 3'd2;
      step(1, 0, 0);
      for (int i = 0; i < 10; i++) step(0, 1, 0);
      step(0, 0, 1);
      chk("R6 done clears", cnt, 0);
      step(0, 1, 0);
      chk("R8 after done ignored", cnt, 0);

      // R5: start wins over retry
      step(1, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 1, 0);
      step(1, 1, 0);
      chk("R5 start beats retry", cnt, 0);
      for (int i = 0; i < 15; i++) step(0, 1, 0);
      chk("R5 full window after restart", abort, 0);
      step(0, 1, 0);
      chk("R5 abort at 16", abort, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      wait (cycles >= 100000);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule